// File: doc/BRIEF.md
# Module clock enable controller

This block is a register-mapped controller for the functional clock of a single peripheral module and for the clock domain that holds it. Software asks for the module clock to be switched on or off by writing a two-bit mode field. The controller then walks an idle-status field through a disabled, a transitioning and a functional state. While it does so it drives the clock-gate enable for the module. The handshake with the module is modelled as a fixed acknowledge delay of `ACK_CYC` cycles.

The request and the outcome are kept apart. A write only states what software wants, so software polls the idle-status field until it settles. A second register controls the domain. Writing the wake command there turns on the domain's gated clocks one after another, `WAKE_STEP` cycles apart, and each one's activity bit rises as it starts. Writing the sleep value clears all activity bits after `SLEEP_CYC` cycles, and only once the module is fully disabled. An optional functional clock enable bit drives a second gate output, which is active only while the module is functional.

The bus is a plain 32-bit single-cycle read/write port. Read data is combinational from the addressed register.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset the module register (byte offset 0x0) reads 0x00030000: mode 0, idle status 3, optional enable 0. The domain register (offset 0x4) reads 0. Both gate outputs are low.
- R2: The mode field is bits [1:0] of the module register. A write of 0 (off) or 2 (on) is stored and reads back unchanged.
- R3: Mode values 1 and 3 are reserved. Writing either leaves the stored mode and the idle status unchanged.
- R4: The idle status is bits [17:16]. After mode 2 is written at a clock edge, it reads 3 until the next edge, then 1 for `ACK_CYC` cycles, then 0 (functional).
- R5: After mode 0 is written while the status is 0, it reads 0 until the next edge, then 1 for `ACK_CYC` cycles, then 3 (disabled).
- R6: `mod_clk_en` is high exactly while the idle status is 1 or 0.
- R7: Bit 18 of the module register is the optional functional clock enable. It is stored on every write to that register and reads back as written. `opt_clk_en` is high only when this bit is 1 and the idle status is 0.
- R8: The domain register's transition field is bits [1:0] and stores any written value. While it holds 2 (wake), activity bit 4+i is set at the (i+1)*`WAKE_STEP`-th clock edge after the write.
- R9: While the transition field holds 1 (sleep) and the module has mode 0 and status 3, all activity bits clear at the `SLEEP_CYC`-th edge of that condition. While the module is not disabled, they hold.
- R10: Transition values 0 and 3 neither set nor clear activity bits.
- R11: Byte offsets 0x8 and 0xC read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of addressed register, 0 when not selected |
| mod_clk_en | output | 1 | Module functional clock gate enable |
| opt_clk_en | output | 1 | Optional functional clock gate enable |

## Verification
The bench builds the block with `ACK_CYC`=3, `NUM_CLK`=3, `WAKE_STEP`=2 and `SLEEP_CYC`=4. At these values every transition and every staggered activity edge falls within a few cycles, so each one is checked at its exact cycle rather than by polling. The small mode field lets the bench sweep all four written values, starting from both the disabled and the functional state. The sleep path is exercised twice: directly, and held off by an enabled module until that module's disable sequence completes.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [1:0] {
        IST_FUNC  = 2'd0,
        IST_TRANS = 2'd1,
        IST_DIS   = 2'd3
    } ist_e;

    localparam logic [1:0] MODE_OFF = 2'd0;
    localparam logic [1:0] MODE_ON  = 2'd2;
    localparam logic [1:0] TR_SLEEP = 2'd1;
    localparam logic [1:0] TR_WAKE  = 2'd2;

    localparam int IST_LSB = 16;
    localparam int OPT_BIT = 18;
    localparam int ACT_LSB = 4;

endpackage

// File: rtl/clkgate_seq.sv
module clkgate_seq
    import clkgate_pkg::*;
#(
    parameter int ACK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_on,
    output ist_e ist
);
    localparam int CNT_W = $clog2(ACK_CYC + 1);

    typedef struct packed {
        ist_e             ist;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.ist)
            IST_DIS: begin
                if (mode_on) begin
                    seq_d.ist = IST_TRANS;
                    seq_d.cnt = '0;
                end
            end
            IST_TRANS: begin
                if (seq_q.cnt == CNT_W'(ACK_CYC - 1)) begin
                    seq_d.ist = mode_on ? IST_FUNC : IST_DIS;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            IST_FUNC: begin
                if (!mode_on) begin
                    seq_d.ist = IST_TRANS;
                    seq_d.cnt = '0;
                end
            end
            default: seq_d.ist = IST_DIS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ist <= IST_DIS;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ist = seq_q.ist;

endmodule

// File: rtl/clkgate_dom.sv
module clkgate_dom
    import clkgate_pkg::*;
#(
    parameter int NUM_CLK   = 3,
    parameter int WAKE_STEP = 2,
    parameter int SLEEP_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         trctl,
    input  logic               mod_idle,
    output logic [NUM_CLK-1:0] act
);
    localparam int WK_MAX = NUM_CLK * WAKE_STEP;
    localparam int WK_W   = $clog2(WK_MAX + 1);
    localparam int SL_W   = $clog2(SLEEP_CYC + 1);

    typedef struct packed {
        logic [NUM_CLK-1:0] act;
        logic [WK_W-1:0]    wk;
        logic [SL_W-1:0]    sl;
    } dom_t;

    dom_t dom_d, dom_q;

    always_comb begin
        dom_d    = dom_q;
        dom_d.wk = '0;
        dom_d.sl = '0;
        if (trctl == TR_WAKE) begin
            dom_d.wk = (dom_q.wk == WK_W'(WK_MAX)) ? dom_q.wk : dom_q.wk + 1'b1;
            for (int i = 0; i < NUM_CLK; i++) begin
                if (dom_q.wk >= WK_W'((i + 1) * WAKE_STEP - 1)) begin
                    dom_d.act[i] = 1'b1;
                end
            end
        end else if (trctl == TR_SLEEP && mod_idle) begin
            if (dom_q.sl == SL_W'(SLEEP_CYC - 1)) begin
                dom_d.act = '0;
            end else begin
                dom_d.sl = dom_q.sl + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_q <= '0;
        end else begin
            dom_q <= dom_d;
        end
    end

    assign act = dom_q.act;

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int NUM_CLK   = 3,
    parameter int ACK_CYC   = 4,
    parameter int WAKE_STEP = 2,
    parameter int SLEEP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mod_clk_en,
    output logic              opt_clk_en
);
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [1:0] mode;
        logic       opt;
        logic [1:0] trctl;
    } regs_t;

    regs_t regs_d, regs_q;

    logic               hit_mod, hit_dom, wr_mod, wr_dom;
    logic [1:0]         cur_mode, cur_trctl;
    ist_e               cur_ist;
    logic [NUM_CLK-1:0] cur_act;
    logic               mod_idle;
    logic               unused_bits;

    assign hit_mod = bus_addr[ADDR_W-1:2] == WORD_W'(0);
    assign hit_dom = bus_addr[ADDR_W-1:2] == WORD_W'(1);
    assign wr_mod  = bus_sel && bus_wr && hit_mod;
    assign wr_dom  = bus_sel && bus_wr && hit_dom;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:19], bus_wdata[17:2]};

    always_comb begin
        regs_d = regs_q;
        if (wr_mod) begin
            if (bus_wdata[1:0] == MODE_OFF || bus_wdata[1:0] == MODE_ON) begin
                regs_d.mode = bus_wdata[1:0];
            end
            regs_d.opt = bus_wdata[OPT_BIT];
        end
        if (wr_dom) begin
            regs_d.trctl = bus_wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cur_mode  = regs_q.mode;
    assign cur_trctl = regs_q.trctl;
    assign mod_idle  = (regs_q.mode == MODE_OFF) && (cur_ist == IST_DIS);

    clkgate_seq #(.ACK_CYC(ACK_CYC)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_on (regs_q.mode == MODE_ON),
        .ist     (cur_ist)
    );

    clkgate_dom #(
        .NUM_CLK   (NUM_CLK),
        .WAKE_STEP (WAKE_STEP),
        .SLEEP_CYC (SLEEP_CYC)
    ) dom_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trctl    (regs_q.trctl),
        .mod_idle (mod_idle),
        .act      (cur_act)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && hit_mod) begin
            bus_rdata[1:0]               = regs_q.mode;
            bus_rdata[IST_LSB +: 2]      = cur_ist;
            bus_rdata[OPT_BIT]           = regs_q.opt;
        end else if (bus_sel && hit_dom) begin
            bus_rdata[1:0]               = regs_q.trctl;
            bus_rdata[ACT_LSB +: NUM_CLK] = cur_act;
        end
    end

    assign mod_clk_en = (cur_ist != IST_DIS);
    assign opt_clk_en = regs_q.opt && (cur_ist == IST_FUNC);

endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk
    import clkgate_pkg::*;
#(
    parameter int NUM_CLK = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_mod,
    input logic               wr_lsb,
    input logic [1:0]         mode,
    input logic [1:0]         ist,
    input logic [1:0]         trctl,
    input logic [NUM_CLK-1:0] act,
    input logic               mod_clk_en,
    input logic               opt_clk_en
);

    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mod && wr_lsb) |=> $stable(mode)); // R3

    AST_ENABLE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (ist == IST_DIS) |=> (ist == IST_DIS || ist == IST_TRANS)); // R4

    AST_FUNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ist == IST_FUNC) |-> ($past(ist) == IST_TRANS && $past(mode) == MODE_ON)); // R4

    AST_DISABLE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (ist == IST_FUNC) |=> (ist != IST_DIS)); // R5

    AST_OPT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        opt_clk_en |-> mod_clk_en); // R7

    AST_ACT_SET_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ((act & ~$past(act)) != '0) |-> ($past(trctl) == TR_WAKE)); // R8

    AST_ACT_CLR_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((~act & $past(act)) != '0) |-> ($past(trctl) == TR_SLEEP && $past(ist) == IST_DIS)); // R9

endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(.NUM_CLK(NUM_CLK)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mod     (wr_mod),
    .wr_lsb     (bus_wdata[0]),
    .mode       (cur_mode),
    .ist        (cur_ist),
    .trctl      (cur_trctl),
    .act        (cur_act),
    .mod_clk_en (mod_clk_en),
    .opt_clk_en (opt_clk_en)
);

// File: tb/clkgate_ctrl_tb_top.sv
module clkgate_ctrl_tb_top;
    localparam int ADDR_W = 4;
    localparam int NCLK   = 3;
    localparam int ACK    = 3;
    localparam int STEP   = 2;
    localparam int SLP    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              mod_clk_en, opt_clk_en;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    clkgate_ctrl #(
        .ADDR_W(ADDR_W), .NUM_CLK(NCLK), .ACK_CYC(ACK),
        .WAKE_STEP(STEP), .SLEEP_CYC(SLP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mod_clk_en(mod_clk_en), .opt_clk_en(opt_clk_en)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] modreg(input logic [1:0] m, input logic [1:0] st, input logic o);
        return {13'd0, o, st, 14'd0, m};
    endfunction

    function automatic logic [31:0] domreg(input logic [1:0] t, input logic [2:0] a);
        return {25'd0, a, 2'd0, t};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [1:0]  smode;
        logic [2:0]  ea;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, r); chk("R1 modreg", r, 32'h00030000);
        rd(4'h4, r); chk("R1 domreg", r, 32'h0);
        chk("R1 gate", {30'd0, mod_clk_en, opt_clk_en}, 32'h0);

        // R4 enable sequence timing, R2 readback, R6 gate
        wr(4'h0, 32'h2);
        rd(4'h0, r); chk("R4 k0", r, modreg(2'd2, 2'd3, 1'b0));
        chk("R6 off k0", {31'd0, mod_clk_en}, 32'h0);
        for (int k = 1; k <= ACK + 1; k++) begin
            @(negedge clk);
            rd(4'h0, r);
            chk("R4 step", r, modreg(2'd2, (k <= ACK) ? 2'd1 : 2'd0, 1'b0));
            chk("R6 on", {31'd0, mod_clk_en}, 32'h1);
        end

        // R3 reserved values while functional
        wr(4'h0, 32'h3);
        wr(4'h0, 32'h1);
        for (int k = 0; k < 3; k++) begin
            rd(4'h0, r); chk("R3 hold on", r, modreg(2'd2, 2'd0, 1'b0));
            @(negedge clk);
        end

        // R5 disable sequence
        wr(4'h0, 32'h0);
        rd(4'h0, r); chk("R5 k0", r, modreg(2'd0, 2'd0, 1'b0));
        for (int k = 1; k <= ACK + 1; k++) begin
            @(negedge clk);
            rd(4'h0, r);
            chk("R5 step", r, modreg(2'd0, (k <= ACK) ? 2'd1 : 2'd3, 1'b0));
            chk("R6 gate", {31'd0, mod_clk_en}, (k <= ACK) ? 32'h1 : 32'h0);
        end

        // R3 reserved values while disabled
        wr(4'h0, 32'h1);
        wr(4'h0, 32'h3);
        for (int k = 0; k < ACK + 2; k++) begin
            rd(4'h0, r); chk("R3 hold off", r, modreg(2'd0, 2'd3, 1'b0));
            chk("R6 stays off", {31'd0, mod_clk_en}, 32'h0);
            @(negedge clk);
        end

        // R2/R3 sweep of every mode value from settled states
        smode = 2'd0;
        for (int i = 0; i < 8; i++) begin
            logic [1:0] v;
            v = 2'((i * 3) % 4);
            wr(4'h0, {30'd0, v});
            if (!v[0]) smode = v;
            repeat (ACK + 2) @(negedge clk);
            rd(4'h0, r);
            chk(v[0] ? "R3 sweep" : "R2 sweep", r,
                modreg(smode, (smode == 2'd2) ? 2'd0 : 2'd3, 1'b0));
        end
        wr(4'h0, 32'h0);
        repeat (ACK + 2) @(negedge clk);

        // R7 optional functional clock enable
        wr(4'h0, 32'h0004_0002);
        chk("R7 k0", {31'd0, opt_clk_en}, 32'h0);
        repeat (ACK) @(negedge clk);
        chk("R7 during trans", {31'd0, opt_clk_en}, 32'h0);
        @(negedge clk);
        rd(4'h0, r); chk("R7 readback", r, 32'h0004_0002);
        chk("R7 opt on", {30'd0, mod_clk_en, opt_clk_en}, 32'h3);
        wr(4'h0, 32'h0004_0000);
        @(negedge clk);
        chk("R7 opt drops", {30'd0, mod_clk_en, opt_clk_en}, 32'h2);
        repeat (ACK + 1) @(negedge clk);
        wr(4'h0, 32'h0);
        rd(4'h0, r); chk("R7 cleared", r, modreg(2'd0, 2'd3, 1'b0));

        // R8 staggered wake
        wr(4'h4, 32'h2);
        for (int k = 0; k <= NCLK * STEP + 1; k++) begin
            if (k > 0) @(negedge clk);
            for (int i = 0; i < NCLK; i++) ea[i] = (k >= (i + 1) * STEP);
            rd(4'h4, r); chk("R8 wake", r, domreg(2'd2, ea));
        end

        // R10 other transition values hold
        wr(4'h4, 32'h0);
        for (int k = 0; k < 6; k++) begin
            rd(4'h4, r); chk("R10 val0", r, domreg(2'd0, 3'b111));
            @(negedge clk);
        end
        wr(4'h4, 32'h3);
        for (int k = 0; k < 6; k++) begin
            rd(4'h4, r); chk("R10 val3", r, domreg(2'd3, 3'b111));
            @(negedge clk);
        end

        // R9 sleep held off by an enabled module
        wr(4'h0, 32'h2);
        repeat (ACK + 1) @(negedge clk);
        wr(4'h4, 32'h1);
        for (int k = 0; k < 2 * SLP; k++) begin
            rd(4'h4, r); chk("R9 held", r, domreg(2'd1, 3'b111));
            @(negedge clk);
        end
        wr(4'h0, 32'h0);
        for (int k = 1; k <= ACK + 1 + SLP; k++) begin
            @(negedge clk);
            rd(4'h4, r);
            chk("R9 after disable", r, domreg(2'd1, (k < ACK + 1 + SLP) ? 3'b111 : 3'b000));
        end

        // R9 direct sleep with module already disabled
        wr(4'h4, 32'h2);
        repeat (NCLK * STEP) @(negedge clk);
        wr(4'h4, 32'h1);
        rd(4'h4, r); chk("R9 k0", r, domreg(2'd1, 3'b111));
        for (int k = 1; k <= SLP; k++) begin
            @(negedge clk);
            rd(4'h4, r);
            chk("R9 sleep", r, domreg(2'd1, (k < SLP) ? 3'b111 : 3'b000));
        end

        // R11 unmapped offsets
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h8, r); chk("R11 rd8", r, 32'h0);
        rd(4'hC, r); chk("R11 rdC", r, 32'h0);
        repeat (ACK + 2) @(negedge clk);
        rd(4'h0, r); chk("R11 modreg", r, modreg(2'd0, 2'd3, 1'b0));
        rd(4'h4, r); chk("R11 domreg", r, domreg(2'd1, 3'b000));
        chk("R11 gate", {30'd0, mod_clk_en, opt_clk_en}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule